// File: doc/BRIEF.md
# Burst Word Address Generator

This block produces the word address that a synchronous burst memory uses on each beat. It captures a fresh external address when one of two active-low address strobes is accepted at a rising clock edge. One strobe comes from the processor side and the other from the controller side. On later edges the block steps through the rest of the aligned four-word group when an active-low advance request is sampled.

The two lowest address bits come from a start value plus a two-bit beat count. The count is combined with the start value in one of two ways, chosen by a static mode input. Linear order adds the count to the start value, modulo 4. Interleaved order XORs the count with the start value. The upper address bits stay fixed for the whole burst.

The processor-side strobe only counts while the active-low chip enable is low. The controller-side strobe is not gated. The chip enable is only looked at on the edge where a strobe is present. A one-cycle flag shows that the address now on the output was loaded from outside at the last edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While the asynchronous active-low reset is low, word_addr is all zeros and addr_loaded is 0.
- R2: A low strb_ctl_n at a rising edge loads addr_in, whatever the value of ce1_n. After that edge, word_addr equals the sampled addr_in and the beat count restarts at 0.
- R3: A low strb_cpu_n at a rising edge loads addr_in when ce1_n is low. When ce1_n is high, strb_cpu_n alone has no effect, and the address holds or advances as if no strobe were present.
- R4: When both strobes are low at an edge, one load of addr_in takes place. The advance input is ignored at that edge, so the first beat after the load shows the start address.
- R5: With mode = 0 (linear), word_addr[1:0] equals (start + count) mod 4, where start is the loaded addr_in[1:0].
- R6: With mode = 1 (interleaved), word_addr[1:0] equals start XOR count.
- R7: An edge with adv_n low and no accepted strobe increments the count by one. The count wraps from 3 to 0, so the address stays in the same four-word group, and word_addr[AW-1:2] does not change.
- R8: An edge with no accepted strobe and adv_n high leaves word_addr unchanged.
- R9: addr_loaded is 1 for exactly the cycle that follows an edge with an accepted strobe, and is 0 after every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | AW | External address captured on an accepted strobe |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low, gated by ce1_n |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low, ungated |
| adv_n | input | 1 | Burst advance request, active low |
| ce1_n | input | 1 | Chip enable, active low, qualifies strb_cpu_n |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved; held static |
| word_addr | output | AW | Current internal word address |
| addr_loaded | output | 1 | High for one cycle after an external address load |

## Verification
The bench sweeps both burst orders against every start offset and sixteen upper-address values. Loads alternate between the controller strobe with the chip enable high and the processor strobe with it low. Six advance beats follow each load, so wrap-around past the fourth beat is separated from a counter that escapes its group. Each burst then adds three cases: a hold cycle, a gated processor strobe that must not reload, and a dual-strobe edge with advance low. These show apart a hold from a step, a gated strobe from an accepted one, and a load from a stray advance on the load edge.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          mode,
  output logic [AW-1:0] word_addr,
  output logic          addr_loaded
);

  localparam int UW = AW - 2;

  logic [UW-1:0] upper_q;
  logic [1:0]    start_q;
  logic [1:0]    beat_q;
  logic          cpu_take, ctl_take, load;
  logic [1:0]    low_bits;

  // processor strobe wins when both are present; gated by the chip enable
  assign cpu_take = !strb_cpu_n && !ce1_n;
  assign ctl_take = !strb_ctl_n && !cpu_take;
  assign load     = cpu_take || ctl_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q     <= '0;
      start_q     <= 2'd0;
      beat_q      <= 2'd0;
      addr_loaded <= 1'b0;
    end else begin
      addr_loaded <= load;
      if (load) begin
        upper_q <= addr_in[AW-1:2];
        start_q <= addr_in[1:0];
        beat_q  <= 2'd0;
      end else if (!adv_n) begin
        beat_q  <= beat_q + 2'd1;
      end
    end
  end

  assign low_bits  = mode ? (start_q ^ beat_q) : (start_q + beat_q);
  assign word_addr = {upper_q, low_bits};

  AST_CTL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_ctl_n |=> (addr_loaded && word_addr == $past(addr_in))); // R2

  AST_CPU_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !ce1_n) |=> (addr_loaded && word_addr == $past(addr_in))); // R3

  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && ce1_n && strb_ctl_n) |=> !addr_loaded); // R3

  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_ctl_n && (strb_cpu_n || ce1_n)) |=> $stable(word_addr[AW-1:2])); // R7

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_ctl_n && (strb_cpu_n || ce1_n) && adv_n) |=> ($stable(word_addr) && !addr_loaded)); // R8

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_ctl_n && (strb_cpu_n || ce1_n) && !adv_n && !mode)
      |=> (mode || word_addr[1:0] == 2'($past(word_addr[1:0]) + 2'd1))); // R5

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1, ce1_n = 1'b1, mode = 1'b0;
  logic [AW-1:0] word_addr;
  logic          addr_loaded;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [AW-3:0] e_up = '0;
  logic [1:0]    e_st = 2'd0, e_ct = 2'd0;
  logic          e_ld = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .mode(mode), .word_addr(word_addr), .addr_loaded(addr_loaded)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = mode ? (e_st ^ e_ct) : 2'(e_st + e_ct);
    return {e_up, lo};
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // drive after a falling edge, let one rising edge pass, check at the next falling edge
  task automatic cyc(input string req, input logic cpu_n, input logic ctl_n,
                     input logic av_n, input logic ce_n, input logic [AW-1:0] a);
    logic ld;
    strb_cpu_n = cpu_n; strb_ctl_n = ctl_n; adv_n = av_n; ce1_n = ce_n; addr_in = a;
    @(posedge clk);
    ld = (!cpu_n && !ce_n) || !ctl_n;
    if (ld) begin
      e_up = a[AW-1:2]; e_st = a[1:0]; e_ct = 2'd0;
    end else if (!av_n) begin
      e_ct = e_ct + 2'd1;
    end
    e_ld = ld;
    @(negedge clk);
    chk(req, word_addr, exp_addr());
    chk("R9", {{(AW-1){1'b0}}, addr_loaded}, {{(AW-1){1'b0}}, e_ld});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", word_addr, '0);
    chk("R1", {{(AW-1){1'b0}}, addr_loaded}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int up = 0; up < 16; up++) begin
          logic [AW-1:0] a, b;
          string ord;
          a = AW'({up[3:0], s[1:0]});
          b = ~a;
          mode = m[0];
          ord = m[0] ? "R6" : "R5";
          if (up[0]) cyc("R2", 1'b1, 1'b0, 1'b0, 1'b1, a);
          else       cyc("R3", 1'b0, 1'b1, 1'b0, 1'b0, a);
          for (int k = 0; k < 6; k++)
            cyc(k >= 3 ? "R7" : ord, 1'b1, 1'b1, 1'b0, up[1], b);
          cyc("R8", 1'b1, 1'b1, 1'b1, 1'b0, b);
          cyc("R3", 1'b0, 1'b1, 1'b1, 1'b1, b);
          cyc("R3", 1'b0, 1'b1, 1'b0, 1'b1, b);
          cyc("R4", 1'b0, 1'b0, 1'b0, up[2], b);
          cyc(ord, 1'b1, 1'b1, 1'b0, 1'b0, a);
        end
      end
    end

    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    rst_n = 1'b0;
    #1;
    chk("R1", word_addr, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule